// File: doc/BRIEF.md
# Timer Capture Channel with Event Prescaler

This block is one channel of a general-purpose timer, used in its capture role. A 2-bit source selection decides whether the channel is an output, in which case the capture logic stays idle, or an input. As an input it listens to one of three edge-strobe sources: its own pin path, the pin path of the neighbouring channel, or an internal trigger. A polarity bit picks rising or falling strobes as the active edges. When an active edge passes the event prescaler, the current value of a free-running 16-bit counter, which is supplied from outside, is latched into the capture register.

The prescaler lets through every active edge, or one in every 2, 4 or 6. It restarts its count when the channel is disabled or when its code changes. A capture flag reports that a new value is waiting. A second capture that arrives while that flag is still set raises an overcapture flag. One clear pulse drops both flags.

A small control state machine owns the selection register. Its states are `ST_OUT` (output mode, no capture), `ST_IN_IDLE` (input selected, channel disabled) and `ST_ARMED` (input selected and enabled). Its transitions are:
- out-to-idle, when an input selection is written;
- idle-to-out, when the output selection is written;
- idle-to-armed, when the enable rises;
- armed-to-idle, when the enable falls.

Selection writes are accepted only while the enable is low.

Top module: `tcap_channel`

## Requirements
- R1: After reset `cap_val` is 0, both flags are 0, and the selection is 00 (output), so strobes cause no capture even with `ch_en` = 1.
- R2: With selection 00 no strobe on any source changes `cap_val` or `cap_flag`.
- R3: Selection 01 takes strobes from source index 0 (own input), 10 from index 1 (neighbour input), and 11 from index 2 (internal trigger). Strobes on the other sources are ignored.
- R4: A write on `sel_wr` is accepted only when `ch_en` = 0. A write made while enabled leaves the old selection in force.
- R5: With `pol_fall` = 0 only `src_rise` strobes are active edges. With `pol_fall` = 1 only `src_fall` strobes are.
- R6: With prescaler code 00 every active edge captures. The `cnt_val` present in the strobe cycle appears on `cap_val` after that clock edge.
- R7: Prescaler codes 01, 10 and 11 capture on the 2nd, 4th and 6th active edge of each run, and then repeat with the same spacing.
- R8: The prescaler count restarts when the channel is disabled. It also restarts when `psc_code` changes, and an active edge in the cycle of the change counts as the first edge under the new code.
- R9: `cap_flag` sets on each capture. A `flag_clr` pulse clears `cap_flag` and `ovr_flag`.
- R10: A capture while `cap_flag` is set, with no `flag_clr` in that cycle, sets `ovr_flag`. A capture in the same cycle as `flag_clr` leaves `cap_flag` = 1 and `ovr_flag` = 0.
- R11: While `ch_en` = 0 no capture happens, and `cap_val` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | 1 | Channel enable |
| sel_wr | input | 1 | Write strobe for the source selection |
| sel_wdata | input | 2 | Selection value: 00 output, 01 own, 10 neighbour, 11 trigger |
| pol_fall | input | 1 | 0: rising strobes are active, 1: falling strobes are active |
| psc_code | input | 2 | Prescaler: 00 /1, 01 /2, 10 /4, 11 /6 |
| src_rise | input | 3 | Rising-edge strobes, index 0 own, 1 neighbour, 2 trigger |
| src_fall | input | 3 | Falling-edge strobes, same indexing |
| cnt_val | input | 16 | Current timer counter value |
| flag_clr | input | 1 | Pulse that clears both flags |
| cap_val | output | 16 | Captured counter value |
| cap_flag | output | 1 | A capture has occurred since the last clear |
| ovr_flag | output | 1 | A capture arrived while `cap_flag` was set |

## Verification
A capture and a flag clear can land in the same cycle, and this is where the flag logic most easily goes wrong. The bench first makes a capture so that `cap_flag` is set. It then raises `flag_clr` together with the next active strobe and expects `cap_flag` = 1, `ovr_flag` = 0 and the new value in `cap_val`. A further capture without a clear must then set `ovr_flag`.

A second collision is a prescaler code change that coincides with an active edge. The bench judges it by which later edge produces the capture.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int SEL_W  = 2;
    localparam int NSRC   = 3;
    localparam int PSC_CW = 3;

    localparam logic [SEL_W-1:0] SEL_OUTPUT = 2'b00;

    typedef enum logic [1:0] {
        ST_OUT     = 2'd0,
        ST_IN_IDLE = 2'd1,
        ST_ARMED   = 2'd2
    } ch_state_e;

    // divide ratio for each prescaler code
    function automatic logic [PSC_CW-1:0] psc_ratio(input logic [1:0] code);
        logic [PSC_CW-1:0] r;
        unique case (code)
            2'b00:   r = PSC_CW'(1);
            2'b01:   r = PSC_CW'(2);
            2'b10:   r = PSC_CW'(4);
            default: r = PSC_CW'(6);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcap_ctrl_fsm.sv
module tcap_ctrl_fsm
    import tcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic [SEL_W-1:0] sel_q,
    output logic             arm
);

    ch_state_e        state_q, state_d;
    logic [SEL_W-1:0] sel_d;

    // selection register: writes accepted only while disabled
    always_comb begin
        sel_d = sel_q;
        if (sel_wr && !ch_en) begin
            sel_d = sel_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OUT: begin
                if (sel_d != SEL_OUTPUT) begin
                    state_d = ch_en ? ST_ARMED : ST_IN_IDLE;
                end
            end
            ST_IN_IDLE: begin
                if (sel_d == SEL_OUTPUT) begin
                    state_d = ST_OUT;
                end else if (ch_en) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (!ch_en) begin
                    state_d = ST_IN_IDLE;
                end
            end
            default: state_d = ST_OUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OUT;
            sel_q   <= SEL_OUTPUT;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
        end
    end

    // outputs of the machine
    always_comb begin
        arm = 1'b0;
        unique case (state_q)
            ST_OUT:     arm = 1'b0;
            ST_IN_IDLE: arm = 1'b0;
            ST_ARMED:   arm = ch_en;
            default:    arm = 1'b0;
        endcase
    end

endmodule

// File: rtl/tcap_edge_sel.sv
module tcap_edge_sel
    import tcap_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             pol_fall,
    input  logic [NSRC-1:0]  src_rise,
    input  logic [NSRC-1:0]  src_fall,
    output logic             evt
);

    logic [NSRC-1:0]  act;
    logic [SEL_W-1:0] idx;

    for (genvar g = 0; g < NSRC; g++) begin : g_pol
        assign act[g] = pol_fall ? src_fall[g] : src_rise[g];
    end

    assign idx = sel - SEL_W'(1);

    always_comb begin
        evt = 1'b0;
        if (sel != SEL_OUTPUT) begin
            evt = act[idx];
        end
    end

endmodule

// File: rtl/tcap_prescaler.sv
module tcap_prescaler
    import tcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       evt,
    input  logic [1:0] psc_code,
    output logic       fire
);

    logic [PSC_CW-1:0] cnt_q, cnt_d, base, ratio;
    logic [1:0]        code_q;

    always_comb begin
        ratio = psc_ratio(psc_code);
        base  = (psc_code != code_q) ? '0 : cnt_q;
        fire  = arm && evt && (base == ratio - PSC_CW'(1));
        if (!arm) begin
            cnt_d = '0;
        end else if (fire) begin
            cnt_d = '0;
        end else if (evt) begin
            cnt_d = base + PSC_CW'(1);
        end else begin
            cnt_d = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= 2'b00;
        end else begin
            cnt_q  <= cnt_d;
            code_q <= psc_code;
        end
    end

endmodule

// File: rtl/tcap_capture.sv
module tcap_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_val  <= '0;
            cap_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (fire) begin
                cap_val <= cnt_val;
            end
            if (flag_clr) begin
                cap_flag <= fire;
                ovr_flag <= 1'b0;
            end else if (fire) begin
                cap_flag <= 1'b1;
                ovr_flag <= ovr_flag | cap_flag;
            end
        end
    end

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  logic             pol_fall,
    input  logic [1:0]       psc_code,
    input  logic [2:0]       src_rise,
    input  logic [2:0]       src_fall,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             ovr_flag
);

    logic [SEL_W-1:0] sel_q;
    logic             arm;
    logic             evt;
    logic             cap_fire;

    tcap_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .sel_q     (sel_q),
        .arm       (arm)
    );

    tcap_edge_sel u_esel (
        .sel      (sel_q),
        .pol_fall (pol_fall),
        .src_rise (src_rise),
        .src_fall (src_fall),
        .evt      (evt)
    );

    tcap_prescaler u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .evt      (evt),
        .psc_code (psc_code),
        .fire     (cap_fire)
    );

    tcap_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (cap_fire),
        .cnt_val  (cnt_val),
        .flag_clr (flag_clr),
        .cap_val  (cap_val),
        .cap_flag (cap_flag),
        .ovr_flag (ovr_flag)
    );

endmodule

// File: rtl/tcap_channel_chk.sv
module tcap_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_en,
    input logic             flag_clr,
    input logic [CNT_W-1:0] cnt_val,
    input logic [1:0]       sel_q,
    input logic             cap_fire,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             ovr_flag
);

    p_out_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 2'b00) |-> !cap_fire);

    p_sel_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ch_en |=> $stable(sel_q));

    p_fire_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (cap_flag && cap_val == $past(cnt_val)));

    p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire && cap_flag && !flag_clr) |=> ovr_flag);

    p_clr_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> !ovr_flag);

    p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> $stable(cap_val));

endmodule

bind tcap_channel tcap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_en    (ch_en),
    .flag_clr (flag_clr),
    .cnt_val  (cnt_val),
    .sel_q    (sel_q),
    .cap_fire (cap_fire),
    .cap_val  (cap_val),
    .cap_flag (cap_flag),
    .ovr_flag (ovr_flag)
);

// File: tb/tcap_channel_tb_top.sv
module tcap_channel_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    // row: {sel[2], pol, psc[2], src[2], fall, nstrobes[4], exp_caps[2]}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b01, 1'b0, 2'b00, 2'd0, 1'b0, 4'd3,  2'd3},
        {2'b01, 1'b0, 2'b01, 2'd0, 1'b0, 4'd5,  2'd2},
        {2'b01, 1'b0, 2'b10, 2'd0, 1'b0, 4'd9,  2'd2},
        {2'b01, 1'b0, 2'b11, 2'd0, 1'b0, 4'd13, 2'd2},
        {2'b10, 1'b0, 2'b00, 2'd1, 1'b0, 4'd2,  2'd2},
        {2'b10, 1'b0, 2'b00, 2'd0, 1'b0, 4'd3,  2'd0},
        {2'b11, 1'b1, 2'b00, 2'd2, 1'b1, 4'd2,  2'd2},
        {2'b11, 1'b1, 2'b00, 2'd2, 1'b0, 4'd4,  2'd0},
        {2'b00, 1'b0, 2'b00, 2'd0, 1'b0, 4'd4,  2'd0},
        {2'b01, 1'b1, 2'b01, 2'd0, 1'b1, 4'd4,  2'd2},
        {2'b11, 1'b0, 2'b10, 2'd2, 1'b0, 4'd3,  2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_en = 1'b0;
    logic        sel_wr = 1'b0;
    logic [1:0]  sel_wdata = 2'b00;
    logic        pol_fall = 1'b0;
    logic [1:0]  psc_code = 2'b00;
    logic [2:0]  src_rise = 3'b000;
    logic [2:0]  src_fall = 3'b000;
    logic [15:0] cnt_val = 16'h0000;
    logic        flag_clr = 1'b0;
    logic [15:0] cap_val;
    logic        cap_flag;
    logic        ovr_flag;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] last_cap = 16'h0000;
    logic [15:0] cv = 16'h0100;

    always #(CLK_PERIOD/2) clk = ~clk;

    tcap_channel dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_en     (ch_en),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .pol_fall  (pol_fall),
        .psc_code  (psc_code),
        .src_rise  (src_rise),
        .src_fall  (src_fall),
        .cnt_val   (cnt_val),
        .flag_clr  (flag_clr),
        .cap_val   (cap_val),
        .cap_flag  (cap_flag),
        .ovr_flag  (ovr_flag)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 2;
            2'b10:   return 4;
            default: return 6;
        endcase
    endfunction

    task automatic cfg(input logic [1:0] sel, input logic pol, input logic [1:0] psc);
        ch_en = 1'b0;
        step();
        sel_wr    = 1'b1;
        sel_wdata = sel;
        pol_fall  = pol;
        psc_code  = psc;
        flag_clr  = 1'b1;
        step();
        sel_wr   = 1'b0;
        flag_clr = 1'b0;
        ch_en    = 1'b1;
        step();
    endtask

    task automatic strobe(input int src, input logic fall, input logic [15:0] val);
        cnt_val = val;
        if (fall) src_fall[src] = 1'b1;
        else      src_rise[src] = 1'b1;
        step();
        src_rise = 3'b000;
        src_fall = 3'b000;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 cap_val after reset", 32'(cap_val), 32'h0);
        check("R1 cap_flag after reset", 32'(cap_flag), 32'h0);
        check("R1 ovr_flag after reset", 32'(ovr_flag), 32'h0);

        // output mode straight after reset, enabled, all strobes
        ch_en = 1'b1;
        step();
        cnt_val  = 16'hAAAA;
        src_rise = 3'b111;
        src_fall = 3'b111;
        step();
        src_rise = 3'b000;
        src_fall = 3'b000;
        check("R1 R2 no capture in output mode", 32'(cap_flag), 32'h0);
        check("R1 R2 cap_val unchanged", 32'(cap_val), 32'h0);

        // table walk: R2 R3 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] sel;
            logic       pol;
            logic [1:0] psc;
            int         src;
            logic       fall;
            int         n;
            int         ex;
            int         dv;
            logic       applies;
            {sel, pol, psc} = VEC[i][13:9];
            src  = int'(VEC[i][8:7]);
            fall = VEC[i][6];
            n    = int'(VEC[i][5:2]);
            ex   = int'(VEC[i][1:0]);
            dv   = div_of(psc);
            applies = (sel != 2'b00) && (src == int'(sel) - 1) && (fall == pol);
            cfg(sel, pol, psc);
            for (int k = 1; k <= n; k++) begin
                cv = cv + 16'h0111;
                strobe(src, fall, cv);
                if (applies && (k % dv == 0)) last_cap = cv;
            end
            check($sformatf("R3 R5 R6 R7 R2 row %0d cap_val", i), 32'(cap_val), 32'(last_cap));
            check($sformatf("R6 R7 R9 row %0d cap_flag", i), 32'(cap_flag), 32'(ex > 0));
            check($sformatf("R7 R10 row %0d ovr_flag", i), 32'(ovr_flag), 32'(ex > 1));
        end

        // R4: selection write while enabled is ignored
        cfg(2'b01, 1'b0, 2'b00);
        sel_wr    = 1'b1;
        sel_wdata = 2'b10;
        step();
        sel_wr = 1'b0;
        strobe(1, 1'b0, 16'h1234);
        check("R4 write while enabled ignored, neighbour idle", 32'(cap_val), 32'(last_cap));
        strobe(0, 1'b0, 16'h2345);
        last_cap = 16'h2345;
        check("R4 old selection still captures", 32'(cap_val), 32'h2345);

        // R8: disable restarts the count
        cfg(2'b01, 1'b0, 2'b01);
        strobe(0, 1'b0, 16'h3001);
        check("R8 first of two no capture", 32'(cap_val), 32'(last_cap));
        ch_en = 1'b0;
        step();
        ch_en = 1'b1;
        step();
        strobe(0, 1'b0, 16'h3002);
        check("R8 count restarted by disable", 32'(cap_val), 32'(last_cap));
        strobe(0, 1'b0, 16'h3003);
        last_cap = 16'h3003;
        check("R8 capture after restart", 32'(cap_val), 32'h3003);

        // R8: code change restarts, edge in that cycle counts first
        cfg(2'b01, 1'b0, 2'b10);
        strobe(0, 1'b0, 16'h3101);
        strobe(0, 1'b0, 16'h3102);
        strobe(0, 1'b0, 16'h3103);
        check("R8 three of four no capture", 32'(cap_val), 32'(last_cap));
        psc_code = 2'b01;
        strobe(0, 1'b0, 16'h3104);
        check("R8 code change edge counts first", 32'(cap_val), 32'(last_cap));
        strobe(0, 1'b0, 16'h3105);
        last_cap = 16'h3105;
        check("R8 second edge under new code", 32'(cap_val), 32'h3105);

        // R9 R10: flags, clear colliding with capture
        cfg(2'b01, 1'b0, 2'b00);
        strobe(0, 1'b0, 16'h4001);
        check("R9 flag set on capture", 32'(cap_flag), 32'h1);
        check("R10 no overcapture on first", 32'(ovr_flag), 32'h0);
        flag_clr = 1'b1;
        strobe(0, 1'b0, 16'h4002);
        flag_clr = 1'b0;
        check("R10 clear+capture cap_flag", 32'(cap_flag), 32'h1);
        check("R10 clear+capture ovr_flag", 32'(ovr_flag), 32'h0);
        check("R10 clear+capture value", 32'(cap_val), 32'h4002);
        strobe(0, 1'b0, 16'h4003);
        last_cap = 16'h4003;
        check("R10 overcapture set", 32'(ovr_flag), 32'h1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        check("R9 clear drops cap_flag", 32'(cap_flag), 32'h0);
        check("R9 clear drops ovr_flag", 32'(ovr_flag), 32'h0);

        // R11: disabled channel does not capture
        ch_en = 1'b0;
        step();
        strobe(0, 1'b0, 16'h5001);
        check("R11 disabled cap_val held", 32'(cap_val), 32'(last_cap));
        check("R11 disabled cap_flag", 32'(cap_flag), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule